// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block lets an external device supply the path overhead bytes of a PLCP frame one bit at a time, in place of the bytes that an internal generator would produce. It drives a bit clock and a cycle marker out to the external device, takes one serial bit on each rising edge of that bit clock, and assembles the bits into bytes. Each finished byte leaves the block with a one-cycle valid strobe and the index of its slot in a fixed repeating sequence of twelve overhead bytes.

A pin-level enable chooses the source. When it is high, the assembled serial bytes are used. When it is low, the block passes through the byte offered on its internal-byte input. The enable is taken only at the start of a sequence, so a change of source never splits a sequence between the two sources. The consuming framer and the internal overhead generator sit outside this block.

Top module: `poh_serial_ins`

## Requirements
- R1: While `rst_ni` is low, `poh_clk_o` is 0, `byte_valid_o` is 0, `byte_o` is 0, `byte_idx_o` is 0 and `poh_frame_o` is 1, because the next bit expected is the MSB of slot 0.
- R2: Once out of reset, `poh_clk_o` is a square wave with a period of `CLK_DIV` clock cycles, high for `CLK_DIV/2` cycles and low for `CLK_DIV/2` cycles.
- R3: `poh_data_i` is sampled on the clock edge where `poh_clk_o` rises. Each byte is taken MSB first, so the first bit sampled for a slot becomes bit 7 of `byte_o`.
- R4: `poh_frame_o` is high for exactly one bit time per sequence: the bit time in which the MSB of slot 0 is expected. It is low for the other 95 bit times.
- R5: The slots run 0 to 11 in this order: Z6, Z5, Z4, Z3, Z2, Z1, spare, B1, G1, spare, spare, C1. Slot 0 follows slot 11 directly, and the bit after the LSB of one slot is the MSB of the next.
- R6: `byte_valid_o` is a one-cycle pulse issued once per slot, on the edge that samples the slot's LSB. `byte_o` and `byte_idx_o` hold that slot's byte and index during the pulse.
- R7: If `poh_ins_en_i` was 1 at the sample of the slot 0 MSB, `byte_o` carries the serial bytes for that whole sequence. If it was 0, `byte_o` carries the value on `int_byte_i` at the edge that samples the slot's LSB.
- R8: Changes on `poh_ins_en_i` at any other bit time have no effect on the current sequence. They take effect only at the next slot 0 MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poh_ins_en_i | input | 1 | 1: use the serial overhead; 0: use the internal bytes |
| poh_data_i | input | 1 | Serial overhead bit from the external source |
| int_byte_i | input | 8 | Overhead byte from the internal generator |
| poh_clk_o | output | 1 | Bit clock sent to the external source |
| poh_frame_o | output | 1 | High during the bit time of the slot 0 MSB |
| byte_o | output | 8 | Selected overhead byte |
| byte_valid_o | output | 1 | One-cycle strobe for a completed byte |
| byte_idx_o | output | 4 | Slot index of `byte_o`, 0 to 11 |

## Verification
On every cycle, the assertions check these properties:
- The bit clock period is exactly `CLK_DIV` cycles.
- Every byte strobe coincides with a rising edge of the bit clock and lasts a single cycle.
- Slot indices advance by one and wrap from 11 to 0.
- The cycle marker rises only together with the strobe for slot 11.

Other behaviours can only be shown by the bench scenarios, which compare the output against bytes the bench built itself. These are the MSB-first assembly of real bit patterns, the choice between serial and internal data, and the rule that enable changes in the middle of a sequence are ignored. The bench scenarios also cover restarting at slot 0 after a reset in the middle of a sequence.

// File: rtl/poh_ins_pkg.sv
package poh_ins_pkg;
  localparam int unsigned POH_BYTES = 12;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IDX_W     = $clog2(POH_BYTES);
  localparam int unsigned CYC_BITS  = POH_BYTES * BYTE_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // slot order; position is behaviour
  typedef enum logic [IDX_W-1:0] {
    SLOT_Z6 = 4'd0,  SLOT_Z5 = 4'd1,  SLOT_Z4 = 4'd2,  SLOT_Z3 = 4'd3,
    SLOT_Z2 = 4'd4,  SLOT_Z1 = 4'd5,  SLOT_XA = 4'd6,  SLOT_B1 = 4'd7,
    SLOT_G1 = 4'd8,  SLOT_XB = 4'd9,  SLOT_XC = 4'd10, SLOT_C1 = 4'd11
  } poh_slot_e;
endpackage

// File: rtl/poh_bitclk_gen.sv
module poh_bitclk_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic samp_o
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(CLK_DIV - 1)) cnt_nxt = '0;
    else                           cnt_nxt = cnt_q + 1'b1;
  end

  // sample strobe lines up with the registered rising edge of bclk_o
  assign samp_o = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      bclk_o <= (cnt_nxt >= CW'(HALF));
    end
  end
endmodule

// File: rtl/poh_seq_ctr.sv
module poh_seq_ctr #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 12,
  localparam int unsigned BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1,
  localparam int unsigned IW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          samp_i,
  output logic [IW-1:0] slot_o,
  output logic          cyc_start_o,
  output logic          byte_last_o
);
  logic [BW-1:0] bit_q;
  logic [IW-1:0] slot_q;

  assign byte_last_o = (bit_q == BW'(BYTE_W - 1));
  assign cyc_start_o = (bit_q == '0) && (slot_q == '0);
  assign slot_o      = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (samp_i) begin
      if (byte_last_o) begin
        bit_q  <= '0;
        slot_q <= (slot_q == IW'(NUM_BYTES - 1)) ? '0 : slot_q + 1'b1;
      end else begin
        bit_q  <= bit_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/poh_shift_asm.sv
module poh_shift_asm #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              din_i,
  output logic [BYTE_W-1:0] byte_nxt_o
);
  logic [BYTE_W-2:0] shift_q;

  // msb first: earlier bits move up
  assign byte_nxt_o = {shift_q, din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shift_q <= '0;
    else if (samp_i) shift_q <= byte_nxt_o[BYTE_W-2:0];
  end
endmodule

// File: rtl/poh_serial_ins.sv
module poh_serial_ins
  import poh_ins_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poh_ins_en_i,
  input  logic             poh_data_i,
  input  logic [BYTE_W-1:0] int_byte_i,
  output logic             poh_clk_o,
  output logic             poh_frame_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic             byte_valid_o,
  output logic [IDX_W-1:0] byte_idx_o
);
  logic  samp;
  logic  cyc_start;
  logic  byte_last;
  idx_t  slot;
  byte_t ser_byte;
  logic  ext_sel_q;

  poh_bitclk_gen #(.CLK_DIV(CLK_DIV)) u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_o (poh_clk_o),
    .samp_o (samp)
  );

  poh_seq_ctr #(.BYTE_W(BYTE_W), .NUM_BYTES(POH_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .samp_i      (samp),
    .slot_o      (slot),
    .cyc_start_o (cyc_start),
    .byte_last_o (byte_last)
  );

  poh_shift_asm #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .samp_i     (samp),
    .din_i      (poh_data_i),
    .byte_nxt_o (ser_byte)
  );

  assign poh_frame_o = cyc_start;

  // source chosen once per sequence, at the slot 0 msb
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ext_sel_q <= 1'b0;
    else if (samp && cyc_start) ext_sel_q <= poh_ins_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      byte_idx_o   <= '0;
    end else begin
      byte_valid_o <= samp && byte_last;
      if (samp && byte_last) begin
        byte_o     <= ext_sel_q ? ser_byte : int_byte_i;
        byte_idx_o <= slot;
      end
    end
  end
endmodule

// File: rtl/poh_ins_chk.sv
module poh_ins_chk
  import poh_ins_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             poh_clk_o,
  input logic             poh_frame_o,
  input logic             byte_valid_o,
  input logic [IDX_W-1:0] byte_idx_o
);
  logic       bclk_d_q;
  logic       seen_rise_q;
  int unsigned gap_q;
  logic       have_idx_q;
  idx_t       last_idx_q;
  idx_t       next_idx;
  logic       rise_det;

  assign rise_det = poh_clk_o && !bclk_d_q;
  assign next_idx = (last_idx_q == idx_t'(SLOT_C1)) ? idx_t'(SLOT_Z6) : last_idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d_q    <= 1'b0;
      seen_rise_q <= 1'b0;
      gap_q       <= 0;
      have_idx_q  <= 1'b0;
      last_idx_q  <= '0;
    end else begin
      bclk_d_q <= poh_clk_o;
      if (rise_det) begin
        seen_rise_q <= 1'b1;
        gap_q       <= 1;
      end else if (gap_q < CLK_DIV + 2) begin
        gap_q <= gap_q + 1;
      end
      if (byte_valid_o) begin
        have_idx_q <= 1'b1;
        last_idx_q <= byte_idx_o;
      end
    end
  end

  p_bclk_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_det && seen_rise_q) |-> (gap_q == CLK_DIV));

  p_valid_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (poh_clk_o && !bclk_d_q));

  p_frame_after_c1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poh_frame_o && have_idx_q && !$stable(poh_frame_o))
      |-> (byte_valid_o && byte_idx_o == idx_t'(SLOT_C1)));

  p_idx_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && have_idx_q) |-> (byte_idx_o == next_idx));

  p_idx_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> (byte_idx_o <= idx_t'(SLOT_C1)));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
endmodule

bind poh_serial_ins poh_ins_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .poh_clk_o    (poh_clk_o),
  .poh_frame_o  (poh_frame_o),
  .byte_valid_o (byte_valid_o),
  .byte_idx_o   (byte_idx_o)
);

// File: tb/poh_serial_ins_tb.sv
`timescale 1ns/1ps
module poh_serial_ins_tb;
  localparam int CLK_DIV = 4;
  localparam int NVEC    = 6;
  // {ext enable, seed}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h00},
    {1'b1, 8'hFF}, {1'b0, 8'h12}, {1'b1, 8'h69}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       poh_ins_en_i = 1'b0;
  logic       poh_data_i = 1'b0;
  logic [7:0] int_byte_i = 8'h00;
  logic       poh_clk_o, poh_frame_o, byte_valid_o;
  logic [7:0] byte_o;
  logic [3:0] byte_idx_o;

  poh_serial_ins #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .poh_ins_en_i (poh_ins_en_i),
    .poh_data_i   (poh_data_i),
    .int_byte_i   (int_byte_i),
    .poh_clk_o    (poh_clk_o),
    .poh_frame_o  (poh_frame_o),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_idx_o   (byte_idx_o)
  );

  always #2 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  int    byte_num = 0;
  string cur_req = "R3 R7";

  typedef struct packed { logic [3:0] idx; logic [7:0] data; } exp_t;
  exp_t exp_q [$];
  exp_t mon_e;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ext_byte(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 37 + 5);
  endfunction

  function automatic logic [7:0] int_val(input int n);
    return 8'h80 ^ 8'(n * 3);
  endfunction

  task automatic send_cycle(input bit ext, input logic [7:0] seed, input int flip_at, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] eb;
      logic [7:0] ib;
      eb = ext_byte(seed, k);
      ib = int_val(byte_num);
      exp_q.push_back({4'(k), (ext ? eb : ib)});
      for (int b = 7; b >= 0; b--) begin
        if (b == 7) begin
          int_byte_i = ib;
          if (k == 0)       poh_ins_en_i = ext;
          if (k == flip_at) poh_ins_en_i = ~ext;  // R8 mid-sequence toggle
        end
        poh_data_i = eb[b];
        chk(poh_frame_o === (k == 0 && b == 7), "R4 frame marker", 32'(poh_frame_o), 32'(k == 0 && b == 7));
        @(posedge poh_clk_o);
        #1;
      end
      byte_num++;
    end
  endtask

  // byte monitor: R5 R6 R7 R8
  logic prev_valid = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (byte_valid_o) begin
        chk(!prev_valid, "R6 single-cycle strobe", 32'(prev_valid), 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", 32'(byte_idx_o), 32'hFFFF);
        end else begin
          mon_e = exp_q.pop_front();
          chk(byte_idx_o == mon_e.idx, "R5 slot index", 32'(byte_idx_o), 32'(mon_e.idx));
          chk(byte_o == mon_e.data, cur_req, 32'(byte_o), 32'(mon_e.data));
        end
      end
      prev_valid = byte_valid_o;
    end else begin
      prev_valid = 1'b0;
    end
  end

  // bit clock shape: R2
  int   run = 0;
  bit   skip_run = 1'b1;
  logic pclk_prev = 1'b0;
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      run = 0;
      skip_run = 1'b1;
      pclk_prev = 1'b0;
    end else begin
      if (poh_clk_o !== pclk_prev) begin
        if (!skip_run) chk(run == CLK_DIV / 2, "R2 bit clock phase length", 32'(run), 32'(CLK_DIV / 2));
        skip_run = 1'b0;
        run = 1;
      end else begin
        run++;
      end
      pclk_prev = poh_clk_o;
    end
  end

  task automatic reset_checks();
    chk(poh_clk_o === 1'b0,    "R1 reset bit clock", 32'(poh_clk_o), 32'd0);
    chk(byte_valid_o === 1'b0, "R1 reset strobe", 32'(byte_valid_o), 32'd0);
    chk(byte_o === 8'h00,      "R1 reset byte", 32'(byte_o), 32'd0);
    chk(byte_idx_o === 4'd0,   "R1 reset index", 32'(byte_idx_o), 32'd0);
    chk(poh_frame_o === 1'b1,  "R1 reset frame marker", 32'(poh_frame_o), 32'd1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #11;
    reset_checks();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table walk: R3 R5 R7 across source and pattern mixes
    for (int i = 0; i < NVEC; i++) begin
      cur_req = VEC[i][8] ? "R3 R7 serial byte" : "R7 internal byte";
      send_cycle(VEC[i][8], VEC[i][7:0], 99, 12);
    end

    // reset in mid-sequence, then restart at slot 0 (R1 R4)
    cur_req = "R3 R7 serial byte";
    send_cycle(1'b1, 8'h5A, 99, 5);
    @(negedge clk_i);
    @(negedge clk_i);
    #1;
    rst_ni = 1'b0;
    #3;
    exp_q.delete();
    reset_checks();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: enable toggles inside a sequence are ignored
    cur_req = "R8 source held for sequence";
    send_cycle(1'b0, 8'h33, 5, 12);
    send_cycle(1'b1, 8'hC7, 4, 12);
    send_cycle(1'b0, 8'h9E, 99, 12);

    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 every slot produced a strobe", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule